// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block sits between a processor's load/store port and a slower word-wide main memory. Each 32-bit byte address is split into a tag, a set index and a line offset. The four ways of the indexed set are compared in parallel, so a read hit returns its word on the next cycle. A read miss fetches the whole 16-byte line as four single-word memory transactions. The fetch starts with the word the processor asked for and wraps around the line. That word goes back to the processor as soon as it arrives, while the rest of the line is still being fetched.

Stores always go to memory (write-through). A store that hits also updates the cached copy. A store that misses leaves the cache untouched (no write-allocate). Each set keeps a 3-bit tree pseudo-LRU state that picks the line to replace. A refill goes to an empty way first, if the set has one. Two free-running counters hold the number of accepted accesses and the number of hits, so that software can compute the hit ratio.

Top module: `sa4_cache`

## Requirements
- R1: Address fields are tag = addr[31:12], set = addr[11:4], word = addr[3:2]. Bits [1:0] are ignored. An access hits only when a way of the indexed set is valid and holds the same tag.
- R2: A read hit raises cpu_rvalid for one cycle, in the cycle after the request is accepted, with the stored word on cpu_rdata. A read hit issues no memory transaction.
- R3: A read miss performs four memory reads inside the missing line. The word index goes requested, requested+1, and so on, modulo 4. The tag and set bits stay the same.
- R4: On a read miss, cpu_rvalid pulses once, in the cycle after the first read beat is acknowledged. It carries that beat's data, before the remaining beats of the line.
- R5: A refilled line becomes valid only after its last beat. If a set holds empty ways, the refill uses the lowest-numbered empty way.
- R6: When all four ways are valid, the victim comes from the set's 3-bit state. Bit0=0 selects pair {0,1} and bit0=1 selects pair {2,3}. Inside the pair, bit1 picks way 0 or 1, and bit2 picks way 2 or 3 (0 = lower way). Every hit and every completed refill sets the bits on that way's path to point away from it.
- R7: A write hit updates the cached word and issues exactly one memory write of the same word address and data.
- R8: A write miss issues exactly one memory write and allocates nothing. A later read of that address misses and returns the written data.
- R9: access_count increases by one for each accepted request. hit_count increases by one for each accepted request that hits.
- R10: cpu_ready is low for the whole of a refill or memory write. A request is accepted only on a clock edge where cpu_req and cpu_ready are both high. mem_req, mem_we and mem_addr stay stable until the cycle in which mem_ack is high.
- R11: A synchronous active-high reset invalidates every line, clears the replacement state and both counters, and leaves cpu_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_rvalid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the pending transaction |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| hit_count | output | 32 | Number of hits since reset |
| access_count | output | 32 | Number of accepted requests since reset |

## Verification
The assertions check the following on every cycle:
- the memory request stays stable until it is acknowledged, and it never overlaps cpu_ready;
- consecutive refill beats step through the line's word index with wrap-around;
- every store produces a matching memory write, and every load produces either a data pulse or a first beat at the requested word;
- the counters move only on accepted requests, and hits never exceed accesses.

The bench scenarios show what only end-to-end data and history can reveal. They check that returned words are correct and that the stored copy changes on a write hit but not on a write miss. They also check that empty ways fill in order, and that the tree state evicts exactly the way the encoding predicts after a particular mix of refills and hits.

// File: rtl/sa4_cache.sv
module sa4_cache #(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  access_count
);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int SETS   = 1 << SET_W;
  localparam int WI_W   = OFF_W - 2;
  localparam int WPL    = 1 << WI_W;
  localparam int LINE_W = 32 * WPL;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE} state_t;
  state_t st;

  logic [TAG_W-1:0]  tag_q  [SETS][4];
  logic [LINE_W-1:0] line_q [SETS][4];
  logic [3:0]        vld_q  [SETS];
  logic [2:0]        lru_q  [SETS];

  logic [TAG_W-1:0] r_tag;
  logic [SET_W-1:0] r_set;
  logic [WI_W-1:0]  r_word, beat;
  logic [1:0]       r_way;
  logic [31:0]      r_wdata;

  wire [TAG_W-1:0] a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] a_set  = cpu_addr[OFF_W +: SET_W];
  wire [WI_W-1:0]  a_word = cpu_addr[2 +: WI_W];
  wire             accept = cpu_req && (st == S_IDLE);
  wire [3:0]       set_vld = vld_q[a_set];
  wire [2:0]       set_lru = lru_q[a_set];

  logic unused_bits;
  assign unused_bits = ^cpu_addr[1:0];

  logic [3:0] match;
  logic [1:0] hit_way, victim;
  logic       hit;

  always_comb begin
    for (int w = 0; w < 4; w++)
      match[w] = set_vld[w] && (tag_q[a_set][w] == a_tag);
    hit     = |match;
    hit_way = match[3] ? 2'd3 : match[2] ? 2'd2 : match[1] ? 2'd1 : 2'd0;
  end

  always_comb begin
    if      (!set_vld[0]) victim = 2'd0;
    else if (!set_vld[1]) victim = 2'd1;
    else if (!set_vld[2]) victim = 2'd2;
    else if (!set_vld[3]) victim = 2'd3;
    else victim = set_lru[0] ? {1'b1, set_lru[2]} : {1'b0, set_lru[1]};
  end

  function automatic logic [2:0] lru_touch(input logic [2:0] old, input logic [1:0] way);
    logic [2:0] n;
    n = old;
    if (way[1]) begin
      n[0] = 1'b0;
      n[2] = ~way[0];
    end else begin
      n[0] = 1'b1;
      n[1] = ~way[0];
    end
    return n;
  endfunction

  wire [WI_W-1:0] m_word = (st == S_FILL) ? WI_W'(r_word + beat) : r_word;

  assign cpu_ready = (st == S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = {r_tag, r_set, m_word, 2'b00};
  assign mem_wdata = r_wdata;

  always_ff @(posedge clk) begin
    cpu_rvalid <= 1'b0;
    if (rst) begin
      st           <= S_IDLE;
      hit_count    <= '0;
      access_count <= '0;
      beat         <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          access_count <= access_count + 1'b1;
          r_tag   <= a_tag;
          r_set   <= a_set;
          r_word  <= a_word;
          r_wdata <= cpu_wdata;
          if (hit) begin
            hit_count    <= hit_count + 1'b1;
            lru_q[a_set] <= lru_touch(set_lru, hit_way);
          end
          if (cpu_we) begin
            st <= S_WRITE;
          end else if (hit) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= line_q[a_set][hit_way][{a_word, 5'd0} +: 32];
          end else begin
            r_way                <= victim;
            vld_q[a_set][victim] <= 1'b0;
            beat                 <= '0;
            st                   <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          if (beat == '0) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= mem_rdata;
          end
          beat <= beat + 1'b1;
          if (beat == WI_W'(WPL - 1)) begin
            vld_q[r_set][r_way] <= 1'b1;
            lru_q[r_set]        <= lru_touch(lru_q[r_set], r_way);
            st                  <= S_IDLE;
          end
        end
        S_WRITE: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && accept && !hit && !cpu_we)
      tag_q[a_set][victim] <= a_tag;
    if (!rst && accept && hit && cpu_we)
      line_q[a_set][hit_way][{a_word, 5'd0} +: 32] <= cpu_wdata;
    if (!rst && st == S_FILL && mem_ack)
      line_q[r_set][r_way][{m_word, 5'd0} +: 32] <= mem_rdata;
  end
endmodule

// File: rtl/sa4_cache_chk.sv
module sa4_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [31:0]       cpu_wdata,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  access_count
);
  localparam int WI_W = OFF_W - 2;

  p_ready_excl_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_wrap_beat_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !mem_we |=> !mem_req ||
      (!mem_we && mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]) &&
       WI_W'(mem_addr[OFF_W-1:2] - $past(mem_addr[OFF_W-1:2])) == WI_W'(1)));

  p_read_first_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_ready && !cpu_we |=> cpu_rvalid ||
      (mem_req && !mem_we && mem_addr[ADDR_W-1:2] == $past(cpu_addr[ADDR_W-1:2])));

  p_write_thru_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_ready && cpu_we |=> mem_req && mem_we &&
      mem_addr[ADDR_W-1:2] == $past(cpu_addr[ADDR_W-1:2]) && mem_wdata == $past(cpu_wdata));

  p_rvalid_src_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(cpu_req && cpu_ready && !cpu_we) || $past(mem_req && mem_ack && !mem_we));

  p_acc_inc_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_ready |=> access_count == $past(access_count) + 1'b1);

  p_acc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(cpu_req && cpu_ready) |=> $stable(access_count) && $stable(hit_count));

  p_hit_bound_r9: assert property (@(posedge clk) disable iff (rst)
    hit_count <= access_count);

  p_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cpu_ready && access_count == '0 && hit_count == '0);
endmodule

bind sa4_cache sa4_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .hit_count(hit_count), .access_count(access_count)
);

// File: tb/sa4_cache_tb.sv
`timescale 1ns/1ps
module sa4_cache_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] hit_count, access_count;

  always #2 clk = ~clk;

  sa4_cache u_dut (.*);

  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0, lat = 0;
  int exp_acc = 0, exp_hits = 0;
  logic [31:0] rd_log [256];
  logic [31:0] wr_addr_last, wr_data_last;
  logic [31:0] store [int unsigned];

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h1357};
  endfunction

  function automatic logic [31:0] memval(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    if (store.exists(w)) return store[w];
    return pattern(w);
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == 2) begin
        lat <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          store[{mem_addr[31:2], 2'b00}] = mem_wdata;
          wr_addr_last = mem_addr;
          wr_data_last = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata <= memval(mem_addr);
          if (n_rd < 256) rd_log[n_rd] = mem_addr;
          n_rd++;
        end
      end else lat <= lat + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  task automatic cpu_access(input bit we, input logic [31:0] a, input logic [31:0] d,
                            output logic [31:0] rd, output int beats, output bit rdy);
    int base;
    base = n_rd;
    rd = '0; beats = 0; rdy = 1'b1;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    if (!we) begin
      while (!cpu_rvalid) @(negedge clk);
      rd = cpu_rdata; beats = n_rd - base; rdy = cpu_ready;
    end
    while (!cpu_ready) @(negedge clk);
  endtask

  task automatic do_read(input logic [31:0] a, input bit exp_hit, input string rq);
    int r0, beats;
    logic [31:0] h0, a0, rd;
    bit rdy;
    r0 = n_rd; h0 = hit_count; a0 = access_count;
    cpu_access(1'b0, a, '0, rd, beats, rdy);
    exp_acc++; exp_hits += int'(exp_hit);
    chk(rd == memval(a), rq, "read data", rd, memval(a));
    chk(hit_count - h0 == 32'(exp_hit), "R1", "hit decision", hit_count - h0, 32'(exp_hit));
    chk(access_count - a0 == 1, "R9", "access step", access_count - a0, 1);
    chk(n_rd - r0 == (exp_hit ? 0 : 4), exp_hit ? "R2" : "R3", "memory reads",
        n_rd - r0, exp_hit ? 0 : 4);
    if (!exp_hit) begin
      chk(beats == 1, "R4", "beats before data", beats, 1);
      chk(rdy == 1'b0, "R10", "ready during fill", 32'(rdy), 0);
      for (int i = 0; i < 4; i++) begin
        logic [1:0] wi;
        logic [31:0] ea;
        wi = a[3:2] + 2'(i);
        ea = {a[31:4], wi, 2'b00};
        chk(rd_log[r0 + i] == ea, "R3", "beat address", rd_log[r0 + i], ea);
      end
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input bit exp_hit,
                          input string rq);
    int r0, w0, beats;
    logic [31:0] h0, rd;
    bit rdy;
    r0 = n_rd; w0 = n_wr; h0 = hit_count;
    cpu_access(1'b1, a, d, rd, beats, rdy);
    exp_acc++; exp_hits += int'(exp_hit);
    chk(n_wr - w0 == 1, rq, "memory writes", n_wr - w0, 1);
    chk(wr_addr_last == {a[31:2], 2'b00}, rq, "write address", wr_addr_last, {a[31:2], 2'b00});
    chk(wr_data_last == d, rq, "write data", wr_data_last, d);
    chk(hit_count - h0 == 32'(exp_hit), rq, "write hit decision", hit_count - h0, 32'(exp_hit));
    chk(n_rd == r0, rq, "no line fetch on write", n_rd - r0, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R11", "ready after reset", 32'(cpu_ready), 1);
    chk(access_count == 0, "R11", "access count", access_count, 0);
    chk(hit_count == 0, "R11", "hit count", hit_count, 0);
    chk(mem_req == 1'b0, "R11", "memory idle", 32'(mem_req), 0);
  endtask

  task automatic t_miss_then_hits();
    do_read(32'h0001_2348, 1'b0, "R4");
    do_read(32'h0001_2340, 1'b1, "R2");
    do_read(32'h0001_234C, 1'b1, "R2");
    do_read(32'h0001_2345, 1'b1, "R1");
    do_read(32'h0002_2348, 1'b0, "R1");
  endtask

  task automatic t_write_hit();
    do_write(32'h0001_2344, 32'hDEAD_BEEF, 1'b1, "R7");
    do_read(32'h0001_2344, 1'b1, "R7");
  endtask

  task automatic t_write_miss();
    do_write(32'h0005_6780, 32'hCAFE_0001, 1'b0, "R8");
    do_read(32'h0005_6780, 1'b0, "R8");
  endtask

  function automatic logic [31:0] s7a(input int t);
    return {20'(t), 8'h7A, 4'h4};
  endfunction

  task automatic t_replacement();
    for (int t = 1; t <= 4; t++) do_read(s7a(t), 1'b0, "R5");
    for (int t = 1; t <= 4; t++) do_read(s7a(t), 1'b1, "R5");
    do_read(s7a(1), 1'b1, "R6");
    do_read(s7a(5), 1'b0, "R6");
    do_read(s7a(1), 1'b1, "R6");
    do_read(s7a(2), 1'b1, "R6");
    do_read(s7a(4), 1'b1, "R6");
    do_read(s7a(5), 1'b1, "R6");
    do_read(s7a(3), 1'b0, "R6");
  endtask

  task automatic t_counters();
    chk(access_count == 32'(exp_acc), "R9", "total accesses", access_count, 32'(exp_acc));
    chk(hit_count == 32'(exp_hits), "R9", "total hits", hit_count, 32'(exp_hits));
  endtask

  initial begin
    t_reset();
    t_miss_then_hits();
    t_write_hit();
    t_write_miss();
    t_replacement();
    t_counters();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    report();
    $finish;
  end
endmodule